// File: doc/BRIEF.md
# Card Slot Status and Control Registers

This block is a small register window that a board controller places next to a removable memory card slot. It has four word registers. One holds a fixed identification word, one is a flash-programming stub that reads zero, and one is a decode stub that reads a fixed value. The fourth is a status word. Its bit 0 follows the level of the slot's write-protect switch. Its bit 3 latches a card-insertion event.

The insertion bit is sticky. It drives a level interrupt toward the interrupt controller, and the interrupt stays asserted until software writes a one to bit 3 of the status word. Both slot inputs are asynchronous to the bus clock, so each passes through a two-flop synchronizer first. Accesses use a single-cycle select strobe. Every access, read or write, gets a registered response one cycle later. The response carries read data and an error flag for any index outside the four-register window.

Top module: `slot_ctl_regs`

## Requirements
- R1: A read of index 0 (byte address bits [1:0] ignored) returns 0x41034003.
- R2: A read of index 1 returns 0x00000000, and a read of index 3 returns 0x00000011.
- R3: Status bit 0 (index 2) equals the write-protect input as it was three rising clock edges earlier: two synchronizer stages and the status flop. All status bits other than 0 and 3 read zero.
- R4: Status bit 3 becomes 1 three edges after the card-insert input is high, and it stays 1 after the input falls.
- R5: A write to index 2 with data bit 3 = 1 clears status bit 3 at the next edge. A write with data bit 3 = 0 changes nothing, and data bits other than bit 3 never affect the status word.
- R6: The interrupt output `irq_o` is high exactly when status bit 3 is 1.
- R7: If the synchronized card-insert level is high in the same cycle as a clearing write, status bit 3 remains 1.
- R8: Writes to indices 0, 1 and 3 have no effect on any state and respond with `rsp_err` = 0.
- R9: An access to an index of 4 or more responds with `rsp_err` = 1 and `rsp_rdata` = 0, and a write there changes no state.
- R10: While reset is high and after it is released, the status word is 0, `irq_o` is 0 and `rsp_valid` is 0.
- R11: `rsp_valid` is high in the cycle after each cycle with `bus_sel` high, and only then. `rsp_rdata` reflects the state before that access's own write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; word index is bits [ADDR_W-1:2] |
| bus_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after `bus_sel` |
| rsp_rdata | output | DATA_W | Read data of the access |
| rsp_err | output | 1 | Access hit an index outside the window |
| wp_in | input | 1 | Write-protect switch level, asynchronous |
| cd_in | input | 1 | Card-insert indication, asynchronous |
| irq_o | output | 1 | Card-insertion interrupt, level |

## Verification
The assertions assume that `bus_sel`, `bus_wr`, `bus_addr` and `bus_wdata` are known and stable around each rising edge. They also assume that the slot inputs have passed the synchronizer, so they reason about the synchronized levels and not the raw pins. The stimulus changes every input only on the falling edge. Card-insert pulses are mostly short and sparse, so that clearing writes often find the bit set. Directed sequences hold the insert line high across a clearing write to exercise the set-wins ordering.

// File: rtl/slot_ctl_pkg.sv
package slot_ctl_pkg;
  // Word indices inside the window; software relies on these positions.
  typedef enum logic [1:0] {
    SLOT_IDX_IDENT  = 2'd0,
    SLOT_IDX_FLASH  = 2'd1,
    SLOT_IDX_STATUS = 2'd2,
    SLOT_IDX_DECODE = 2'd3
  } slot_idx_e;

  localparam int STAT_WP_BIT = 0;
  localparam int STAT_CD_BIT = 3;
  localparam int IN_COUNT    = 2;   // write-protect, card-insert
  localparam int IN_WP       = 0;
  localparam int IN_CD       = 1;
endpackage

// File: rtl/slot_sync.sv
module slot_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= '0;
          else     stage_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= '0;
          else     stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/slot_status.sv
module slot_status (
  input  logic clk,
  input  logic rst,
  input  logic wp_s,
  input  logic cd_s,
  input  logic clr_i,
  output logic wp_q,
  output logic cd_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q <= 1'b0;
      cd_q <= 1'b0;
    end else begin
      wp_q <= wp_s;
      if (cd_s)       cd_q <= 1'b1;   // insertion wins over a clear
      else if (clr_i) cd_q <= 1'b0;
    end
  end

  AST_WP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (wp_q == $past(wp_s))); // R3
  AST_CD_STICKY: assert property (@(posedge clk) disable iff (rst)
    (cd_q && !clr_i) |=> cd_q); // R4
  AST_CD_ROSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(cd_q) |-> $past(cd_s)); // R4
  AST_CD_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !cd_s) |=> !cd_q); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    cd_s |=> cd_q); // R7
endmodule

// File: rtl/slot_bus.sv
module slot_bus
  import slot_ctl_pkg::*;
#(
  parameter int unsigned            ADDR_W    = 8,
  parameter int unsigned            DATA_W    = 32,
  parameter logic [DATA_W-1:0]      ID_VALUE  = 32'h4103_4003,
  parameter logic [DATA_W-1:0]      DEC_VALUE = 32'h0000_0011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              stat_wp,
  input  logic              stat_cd,
  output logic              clr_o,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic              in_map;
  slot_idx_e         reg_sel;
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] status_word;

  assign idx     = bus_addr[ADDR_W-1:2];
  assign in_map  = (idx >> 2) == '0;
  assign reg_sel = slot_idx_e'(idx[1:0]);

  always_comb begin
    status_word              = '0;
    status_word[STAT_WP_BIT] = stat_wp;
    status_word[STAT_CD_BIT] = stat_cd;
  end

  always_comb begin
    rd_val = '0;
    if (in_map) begin
      unique case (reg_sel)
        SLOT_IDX_IDENT:  rd_val = ID_VALUE;
        SLOT_IDX_FLASH:  rd_val = '0;
        SLOT_IDX_STATUS: rd_val = status_word;
        SLOT_IDX_DECODE: rd_val = DEC_VALUE;
      endcase
    end
  end

  assign clr_o = bus_sel && bus_wr && in_map &&
                 (reg_sel == SLOT_IDX_STATUS) && bus_wdata[STAT_CD_BIT];

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata, bus_addr[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= bus_sel;
      rsp_rdata <= bus_sel ? rd_val : '0;
      rsp_err   <= bus_sel && !in_map;
    end
  end

  AST_RSP_AFTER_SEL: assert property (@(posedge clk) disable iff (rst)
    bus_sel |=> rsp_valid); // R11
  AST_RSP_QUIET: assert property (@(posedge clk) disable iff (rst)
    !bus_sel |=> !rsp_valid); // R11
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_rdata == '0)); // R9
  AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_valid); // R9
  AST_CLR_IN_MAP: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && !in_map) |-> !clr_o); // R9
endmodule

// File: rtl/slot_ctl_regs.sv
module slot_ctl_regs
  import slot_ctl_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 8,
  parameter int unsigned       DATA_W      = 32,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] ID_VALUE    = 32'h4103_4003,
  parameter logic [DATA_W-1:0] DEC_VALUE   = 32'h0000_0011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  input  logic              wp_in,
  input  logic              cd_in,
  output logic              irq_o
);
  logic [IN_COUNT-1:0] raw_in;
  logic [IN_COUNT-1:0] sync_in;
  logic                clr;
  logic                st_wp;
  logic                st_cd;

  assign raw_in[IN_WP] = wp_in;
  assign raw_in[IN_CD] = cd_in;

  slot_sync #(.WIDTH(IN_COUNT), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d_i (raw_in),
    .q_o (sync_in)
  );

  slot_status status_i (
    .clk   (clk),
    .rst   (rst),
    .wp_s  (sync_in[IN_WP]),
    .cd_s  (sync_in[IN_CD]),
    .clr_i (clr),
    .wp_q  (st_wp),
    .cd_q  (st_cd)
  );

  slot_bus #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .ID_VALUE(ID_VALUE), .DEC_VALUE(DEC_VALUE)
  ) bus_i (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .stat_wp   (st_wp),
    .stat_cd   (st_cd),
    .clr_o     (clr),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
  );

  assign irq_o = st_cd;

  AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(sync_in[IN_CD])); // R6
endmodule

// File: tb/slot_ctl_regs_tb_top.sv
module slot_ctl_regs_tb_top;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          rsp_err;
  logic          wp_in = 1'b0;
  logic          cd_in = 1'b0;
  logic          irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  slot_ctl_regs dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .wp_in(wp_in),
    .cd_in(cd_in), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Reference values derived from the requirement list.
  function automatic logic [31:0] ref_read(input int idx, input bit wp, input bit cd);
    case (idx)
      0: return 32'h4103_4003;              // R1
      1: return 32'h0;                      // R2
      2: return {28'h0, cd, 2'b00, wp};     // R3
      3: return 32'h0000_0011;              // R2
      default: return 32'h0;                // R9
    endcase
  endfunction

  function automatic string ref_tag(input int idx);
    case (idx)
      0: return "R1";
      1, 3: return "R2";
      2: return "R3";
      default: return "R9";
    endcase
  endfunction

  // Cycle model: two synchronizer stages, then the status flops.
  logic [1:0]  m_s1, m_s2;
  logic        m_wp, m_cd;
  logic        e_valid, e_err;
  logic [31:0] e_rdata;
  string       e_tag;
  always @(posedge clk) begin
    int idx;
    idx = int'(bus_addr >> 2);
    if (rst) begin
      m_s1 <= '0; m_s2 <= '0; m_wp <= 1'b0; m_cd <= 1'b0;
      e_valid <= 1'b0; e_err <= 1'b0; e_rdata <= '0; e_tag <= "R10";
    end else begin
      m_s1 <= {cd_in, wp_in};
      m_s2 <= m_s1;
      m_wp <= m_s2[0];
      if (m_s2[1]) m_cd <= 1'b1;
      else if (bus_sel && bus_wr && idx == 2 && bus_wdata[3]) m_cd <= 1'b0;
      e_valid <= bus_sel;
      e_err   <= bus_sel && idx > 3;
      e_rdata <= bus_sel ? ref_read(idx, m_wp, m_cd) : 32'h0;
      e_tag   <= ref_tag(idx);
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(rsp_valid == e_valid, "R11 rsp_valid", 32'(rsp_valid), 32'(e_valid));
      check(irq_o == m_cd, "R6 irq_o", 32'(irq_o), 32'(m_cd));
      if (e_valid) begin
        check(rsp_rdata == e_rdata, e_tag, rsp_rdata, e_rdata);
        check(rsp_err == e_err, "R9 rsp_err", 32'(rsp_err), 32'(e_err));
      end
    end
  end

  task automatic access(input bit wr, input int idx, input logic [31:0] wd,
                        output logic [31:0] rd, output logic er);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = AW'(idx << 2); bus_wdata = wd;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd = rsp_rdata; er = rsp_err;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd;
    logic        er;
    void'($urandom(32'h1c3d_57a9));
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0 && irq_o == 1'b0, "R10 reset outputs",
          {30'h0, rsp_valid, irq_o}, 32'h0);
    rst = 1'b0;
    idle(2);
    check(irq_o == 1'b0, "R10 irq after reset", 32'(irq_o), 32'h0);
    access(0, 2, 0, rd, er);
    check(rd == 32'h0, "R10 status after reset", rd, 32'h0);
    access(0, 0, 0, rd, er);
    check(rd == 32'h4103_4003, "R1 ident", rd, 32'h4103_4003);
    access(0, 1, 0, rd, er);
    check(rd == 32'h0, "R2 flash stub", rd, 32'h0);
    access(0, 3, 0, rd, er);
    check(rd == 32'h11, "R2 decode stub", rd, 32'h11);

    wp_in = 1'b1;
    idle(3);
    access(0, 2, 0, rd, er);
    check(rd == 32'h1, "R3 wp tracked", rd, 32'h1);

    cd_in = 1'b1;
    @(negedge clk); cd_in = 1'b0;
    idle(2);
    check(irq_o == 1'b1, "R6 irq raised", 32'(irq_o), 32'h1);
    idle(5);
    access(0, 2, 0, rd, er);
    check(rd == 32'h9, "R4 sticky insert", rd, 32'h9);

    access(1, 2, 32'hFFFF_FFF7, rd, er);
    access(0, 2, 0, rd, er);
    check(rd == 32'h9, "R5 no clear without bit3", rd, 32'h9);

    access(1, 1, 32'hFFFF_FFFF, rd, er);
    check(er == 1'b0, "R8 flash write err", 32'(er), 32'h0);
    access(1, 3, 32'hFFFF_FFFF, rd, er);
    check(er == 1'b0, "R8 decode write err", 32'(er), 32'h0);
    access(1, 0, 32'hFFFF_FFFF, rd, er);
    access(0, 2, 0, rd, er);
    check(rd == 32'h9, "R8 status untouched", rd, 32'h9);

    access(1, 5, 32'h8, rd, er);
    check(er == 1'b1 && rd == 32'h0, "R9 out of window write",
          {rd[30:0], er}, 32'h1);
    access(0, 2, 0, rd, er);
    check(rd == 32'h9, "R9 status untouched", rd, 32'h9);

    access(1, 2, 32'h8, rd, er);
    check(rd == 32'h9, "R11 pre-write data", rd, 32'h9);
    access(0, 2, 0, rd, er);
    check(rd == 32'h1, "R5 cleared", rd, 32'h1);
    check(irq_o == 1'b0, "R6 irq dropped", 32'(irq_o), 32'h0);

    cd_in = 1'b1;
    idle(4);
    access(1, 2, 32'h8, rd, er);
    cd_in = 1'b0;
    access(0, 2, 0, rd, er);
    check(rd == 32'h9, "R7 set wins over clear", rd, 32'h9);
    idle(4);
    access(1, 2, 32'h8, rd, er);
    access(0, 2, 0, rd, er);
    check(rd == 32'h1, "R5 clear after input low", rd, 32'h1);

    // Random phase: model comparison on every cycle.
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      bus_sel   = ($urandom_range(0, 2) != 0);
      bus_wr    = $urandom_range(0, 1) == 1;
      bus_addr  = AW'($urandom_range(0, 31));
      bus_wdata = $urandom();
      wp_in     = ($urandom_range(0, 9) == 0) ? ~wp_in : wp_in;
      cd_in     = ($urandom_range(0, 11) == 0);
    end
    @(negedge clk);
    bus_sel = 1'b0; cd_in = 1'b0;
    idle(4);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule